// File: doc/BRIEF.md
# Register-Launched Single-Byte Two-Wire Bus Master

This block is a two-wire serial bus master (I2C-style) that software drives through four byte-wide registers. The software first sets the protocol choice, a byte address and a write data byte. It then writes the target register, which holds the 7-bit device address and the direction bit. That write alone launches one bus cycle, which moves exactly one data byte in either direction. When the read completes, the received byte replaces the contents of the data register.

With the protocol bit clear, the device address is followed by a byte-address phase. A read in this mode then issues a repeated START and the device address again with the read direction. With the protocol bit set, only the device address precedes the data byte. The control/status register reports two busy flags: one for the requested cycle, and one that mirrors an external EEPROM default-load sequence. It also holds a sticky no-acknowledge error flag. Both bus lines are open-drain: the block only ever pulls them low.

Register select map: 0 = target (bits 7:1 address, bit 0 direction, 1 = read), 1 = control/status, 2 = byte address, 3 = data.

Top module: `serial_byte_master`

## Requirements
- R1: After reset, register 0 reads 0xA0 and registers 1, 2 and 3 read 0x00.
- R2: A write to register 0 while neither busy flag is set stores the byte and sets status bit 5 (cycle busy) on the next clock.
- R3: With control bit 7 = 0 and direction 0, the bus carries START, {addr,0}, byte address, data byte, STOP, and every byte is acknowledged by the device.
- R4: With control bit 7 = 1 and direction 0, the bus carries START, {addr,0}, data byte, STOP.
- R5: With control bit 7 = 0 and direction 1, the bus carries START, {addr,0}, byte address, repeated START, {addr,1}, then one byte from the device answered with a NACK (SDA high), then STOP. The received byte then reads back from register 3.
- R6: With control bit 7 = 1 and direction 1, the bus carries START, {addr,1}, one byte from the device answered with a NACK, STOP, and the byte reads back from register 3.
- R7: Status bit 5 clears once the STOP has been generated. While it is clear, the block pulls neither SCL nor SDA low.
- R8: A NACK on any byte the master sends ends the cycle with a STOP, with no further bytes, and sets status bit 0. That bit stays set until software writes register 1 with bit 0 = 1.
- R9: A write to register 0 while status bit 5 is set is ignored: register 0 keeps its value and no further cycle starts.
- R10: Status bit 4 follows the EEPROM-load busy input. While that input is high, a write to register 0 is ignored and no cycle starts.
- R11: The master's SDA changes while SCL is high only to form a START or a STOP. Each SCL high phase of a data bit lasts 2*QTR_CYCLES clocks.
- R12: In register 1, bit 6 and bits 3:1 read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Fundamental reset, active low |
| reg_sel | input | 2 | Register select |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data of the selected register |
| eep_load_busy | input | 1 | EEPROM default-load sequence active |
| sda_in | input | 1 | Sampled level of the SDA line |
| scl_low | output | 1 | Pull the SCL line low |
| sda_low | output | 1 | Pull the SDA line low |

## Verification
The assertions assume that reg_sel and reg_wdata are valid on every cycle in which reg_wr is high. They assume that eep_load_busy changes only between cycles, and that sda_in is the resolved line level. The SCL-high check applies only to what the master itself drives on SDA.

The bench keeps within these limits by driving every input on the falling clock edge. It resolves SDA as a wired AND of the master and a device model. The device model changes SDA only on falling SCL edges and never stretches the clock. The sweeps cover both protocol settings, both directions and several addresses. They also place a NACK at each byte the master sends.

// File: rtl/serial_byte_master.sv
module serial_byte_master #(
  parameter int QTR_CYCLES = 125,
  parameter logic [7:0] TGT_RST = 8'hA0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] reg_sel,
  input  logic       reg_wr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       eep_load_busy,
  input  logic       sda_in,
  output logic       scl_low,
  output logic       sda_low
);
  localparam int CW = (QTR_CYCLES > 1) ? $clog2(QTR_CYCLES) : 1;

  typedef enum logic [2:0] {IDLE, STRT, TX, RX, STP} st_t;

  st_t        st;
  logic [1:0] q, seg;
  logic [CW-1:0] cnt;
  logic [7:0] sh, tgt, baddr, dat;
  logic [3:0] bc;
  logic       nak, prot, cur_prot, err;

  wire busy       = (st != IDLE);
  wire tick       = (cnt == CW'(QTR_CYCLES - 1));
  wire launch     = reg_wr && reg_sel == 2'd0 && !busy && !eep_load_busy;
  wire cond_phase = (st == STRT) || (st == STP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= IDLE; q <= '0; seg <= '0; cnt <= '0; sh <= '0; bc <= '0;
      tgt <= TGT_RST; baddr <= '0; dat <= '0;
      nak <= 1'b0; prot <= 1'b0; cur_prot <= 1'b0; err <= 1'b0;
    end else begin
      if (reg_wr) begin
        case (reg_sel)
          2'd0: if (launch) tgt <= reg_wdata;
          2'd1: begin
            prot <= reg_wdata[7];
            if (reg_wdata[0]) err <= 1'b0;
          end
          2'd2: baddr <= reg_wdata;
          default: dat <= reg_wdata;
        endcase
      end
      if (launch) begin
        st <= STRT; q <= '0; cnt <= '0; seg <= 2'd0; cur_prot <= prot;
      end else if (busy) begin
        cnt <= tick ? '0 : cnt + 1'b1;
        if (tick) begin
          q <= q + 1'b1;
          case (st)
            STRT: if (q == 2'd3) begin
              st <= TX; bc <= '0;
              sh <= (seg == 2'd2) ? {tgt[7:1], 1'b1} : {tgt[7:1], tgt[0] & cur_prot};
            end
            TX: begin
              if (q == 2'd2 && bc == 4'd8) nak <= sda_in;
              if (q == 2'd3) begin
                if (bc != 4'd8) begin
                  bc <= bc + 1'b1; sh <= {sh[6:0], 1'b0};
                end else if (nak) begin
                  st <= STP; err <= 1'b1;
                end else begin
                  bc <= '0;
                  case (seg)
                    2'd0: if (!cur_prot) begin
                      sh <= baddr; seg <= 2'd1;
                    end else if (tgt[0]) begin
                      st <= RX; seg <= 2'd3;
                    end else begin
                      sh <= dat; seg <= 2'd3;
                    end
                    2'd1: if (tgt[0]) begin
                      st <= STRT; seg <= 2'd2;
                    end else begin
                      sh <= dat; seg <= 2'd3;
                    end
                    2'd2: begin st <= RX; seg <= 2'd3; end
                    default: st <= STP;
                  endcase
                end
              end
            end
            RX: begin
              if (q == 2'd2 && bc != 4'd8) sh <= {sh[6:0], sda_in};
              if (q == 2'd3) begin
                if (bc != 4'd8) bc <= bc + 1'b1;
                else begin dat <= sh; st <= STP; end
              end
            end
            STP: if (q == 2'd3) st <= IDLE;
            default: st <= IDLE;
          endcase
        end
      end
    end
  end

  always_comb begin
    case (st)
      STRT, TX, RX: scl_low = (q == 2'd0) || (q == 2'd3);
      STP:          scl_low = (q == 2'd0);
      default:      scl_low = 1'b0;
    endcase
    case (st)
      STRT:    sda_low = q[1];
      TX:      sda_low = (bc != 4'd8) && !sh[7];
      STP:     sda_low = !q[1];
      default: sda_low = 1'b0;
    endcase
    case (reg_sel)
      2'd0:    reg_rdata = tgt;
      2'd1:    reg_rdata = {prot, 1'b0, busy, eep_load_busy, 3'b000, err};
      2'd2:    reg_rdata = baddr;
      default: reg_rdata = dat;
    endcase
  end
endmodule

module serial_byte_master_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] reg_sel,
  input logic       reg_wr,
  input logic [7:0] reg_wdata,
  input logic       eep_load_busy,
  input logic       scl_low,
  input logic       sda_low,
  input logic       busy,
  input logic       err,
  input logic       cond_phase,
  input logic [7:0] tgt
);
  p_launch_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && reg_wr && reg_sel == 2'd0 && !eep_load_busy) |=> busy);

  p_idle_lines_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!scl_low && !sda_low));

  p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !(reg_wr && reg_sel == 2'd1 && reg_wdata[0])) |=> err);

  p_tgt_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && reg_wr && reg_sel == 2'd0) |=> $stable(tgt));

  p_eep_block_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && eep_load_busy) |=> !busy);

  p_sda_scl_high_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!scl_low && !$past(scl_low) && sda_low != $past(sda_low)) |-> cond_phase);
endmodule

bind serial_byte_master serial_byte_master_chk i_chk (
  .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
  .reg_wdata(reg_wdata), .eep_load_busy(eep_load_busy),
  .scl_low(scl_low), .sda_low(sda_low), .busy(busy), .err(err),
  .cond_phase(cond_phase), .tgt(tgt)
);

// File: tb/test_serial_byte_master.sv
`timescale 1ns/1ps
module test_serial_byte_master;
  localparam int Q = 2;
  localparam int MAXCYC = 200000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] reg_sel = '0;
  logic reg_wr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic eep_load_busy = 1'b0;
  logic scl_low, sda_low, scl, sda;
  logic slave_low = 1'b0;

  int checks = 0, failures = 0;
  int pos = 0, nstart = 0, nstop = 0, hbad = 0, rd_idx = -1;
  bit pend_valid = 0, pend_bit = 0;
  bit lg [0:63];
  logic [3:0] ack_mask = '0;
  logic [7:0] rd_val = '0;
  time t_rise = 0;

  always #10 clk = ~clk;

  assign scl = ~scl_low;
  assign sda = ~(sda_low | slave_low);

  serial_byte_master #(.QTR_CYCLES(Q)) i_serial_byte_master (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .eep_load_busy(eep_load_busy),
    .sda_in(sda), .scl_low(scl_low), .sda_low(sda_low));

  always @(posedge scl) begin pend_bit = sda; pend_valid = 1; t_rise = $time; end
  always @(negedge sda) if (scl === 1'b1 && rst_n) begin nstart++; pend_valid = 0; end
  always @(posedge sda) if (scl === 1'b1 && rst_n) begin nstop++; pend_valid = 0; end
  always @(negedge scl) begin
    if (pend_valid) begin
      if (pos < 64) lg[pos] = pend_bit;
      pos++;
      if ($time - t_rise != 2 * Q * 20) hbad++;
      pend_valid = 0;
    end
    if (pos % 9 == 8) slave_low = (pos / 9 < 4) ? ack_mask[pos / 9] : 1'b0;
    else if (pos / 9 == rd_idx) slave_low = ~rd_val[7 - (pos % 9)];
    else slave_low = 1'b0;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk); reg_sel = s; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] s, output logic [7:0] v);
    @(negedge clk); reg_sel = s; #1 v = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [7:0] v;
    for (int i = 0; i < 4000; i++) begin
      rd(2'd1, v);
      if (!v[5]) break;
    end
  endtask

  task automatic arm_slave(input logic [3:0] am, input int ri, input logic [7:0] rv);
    pos = 0; pend_valid = 0; slave_low = 0; nstart = 0; nstop = 0;
    ack_mask = am; rd_idx = ri; rd_val = rv;
  endtask

  task automatic run_xfer(input bit p, input logic [7:0] sa, input logic [7:0] ba,
                          input logic [7:0] wd, input logic [7:0] rv, input int nk,
                          input string req);
    logic [7:0] ex [0:3];
    logic [7:0] v, got;
    logic [3:0] am;
    int n, nobs, xs;
    bit rw = sa[0];
    if (!p) begin
      ex[0] = {sa[7:1], 1'b0}; ex[1] = ba;
      if (rw) begin ex[2] = {sa[7:1], 1'b1}; ex[3] = rv; n = 4; end
      else begin ex[2] = wd; n = 3; end
    end else begin
      ex[0] = sa; ex[1] = rw ? rv : wd; n = 2;
    end
    am = 4'b0;
    for (int b = 0; b < n; b++) am[b] = 1'b1;
    if (rw) am[n-1] = 1'b0;
    if (nk >= 0) am[nk] = 1'b0;
    nobs = (nk >= 0) ? nk + 1 : n;
    xs = (!p && rw && nobs > 2) ? 2 : 1;
    wr(2'd1, {p, 6'b0, 1'b1});
    wr(2'd2, ba);
    wr(2'd3, wd);
    arm_slave(am, rw ? n - 1 : -1, rv);
    wr(2'd0, sa);
    rd(2'd1, v);
    chk(v[5] == 1'b1, "R2", v, 8'h20);
    wait_idle();
    rd(2'd1, v);
    chk(v[5] == 1'b0, "R7", v[5], 0);
    chk(v[0] == (nk >= 0), (nk >= 0) ? "R8" : req, v[0], nk >= 0);
    chk(pos == 9 * nobs, (nk >= 0) ? "R8" : req, pos, 9 * nobs);
    for (int b = 0; b < nobs && b < 4; b++) begin
      for (int i = 0; i < 8; i++) got[7 - i] = lg[9 * b + i];
      chk(got == ex[b], req, got, ex[b]);
      chk(lg[9 * b + 8] == ((nk == b) || (rw && nk < 0 && b == n - 1)), req,
          lg[9 * b + 8], 0);
    end
    chk(nstart == xs && nstop == 1, "R11", nstart * 16 + nstop, xs * 16 + 1);
    if (rw && nk < 0) begin
      rd(2'd3, v);
      chk(v == rv, req, v, rv);
    end
    chk(scl === 1'b1 && sda === 1'b1, "R7", {scl, sda}, 3);
  endtask

  initial begin
    #(MAXCYC * 20);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] v;
    logic [6:0] addrs [0:3];
    addrs[0] = 7'h50; addrs[1] = 7'h2A; addrs[2] = 7'h7F; addrs[3] = 7'h01;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rd(2'd0, v); chk(v == 8'hA0, "R1", v, 8'hA0);
    rd(2'd1, v); chk(v == 8'h00, "R1", v, 8'h00);
    chk((v & 8'h4E) == 0, "R12", v, 0);
    rd(2'd2, v); chk(v == 8'h00, "R1", v, 8'h00);
    rd(2'd3, v); chk(v == 8'h00, "R1", v, 8'h00);

    for (int p = 0; p < 2; p++)
      for (int rwv = 0; rwv < 2; rwv++)
        for (int i = 0; i < 4; i++)
          run_xfer(p[0], {addrs[i], rwv[0]}, 8'(i * 29 + 3), 8'h5A ^ 8'(i * 37),
                   8'hC5 + 8'(i * 17),
                   -1, (p == 0) ? (rwv == 0 ? "R3" : "R5") : (rwv == 0 ? "R4" : "R6"));

    for (int k = 0; k < 3; k++) begin
      run_xfer(1'b0, 8'hA0, 8'h40, 8'h99, 8'h00, k, "R8");
      repeat (20) @(negedge clk);
      rd(2'd1, v); chk(v[0] == 1'b1, "R8", v, 1);
      wr(2'd1, 8'h00);
      rd(2'd1, v); chk(v[0] == 1'b1, "R8", v, 1);
      wr(2'd1, 8'h01);
      rd(2'd1, v); chk(v[0] == 1'b0, "R8", v, 0);
      chk((v & 8'h4E) == 0, "R12", v, 0);
    end
    run_xfer(1'b1, 8'h6E, 8'h00, 8'h33, 8'h00, 0, "R8");

    wr(2'd1, 8'h81);
    wr(2'd3, 8'h12);
    arm_slave(4'b0011, -1, 8'h00);
    wr(2'd0, 8'h6E);
    wr(2'd0, 8'h24);
    rd(2'd0, v); chk(v == 8'h6E, "R9", v, 8'h6E);
    wait_idle();
    repeat (40) @(negedge clk);
    rd(2'd0, v); chk(v == 8'h6E, "R9", v, 8'h6E);
    chk(nstart == 1 && pos == 18, "R9", nstart * 256 + pos, 256 + 18);

    eep_load_busy = 1'b1;
    arm_slave(4'b1111, -1, 8'h00);
    rd(2'd1, v); chk(v[4] == 1'b1, "R10", v, 8'h90);
    wr(2'd0, 8'h3C);
    repeat (60) @(negedge clk);
    rd(2'd1, v); chk(v[5] == 1'b0, "R10", v, 8'h90);
    rd(2'd0, v); chk(v == 8'h6E, "R10", v, 8'h6E);
    chk(nstart == 0 && scl === 1'b1, "R10", nstart, 0);
    eep_load_busy = 1'b0;
    rd(2'd1, v); chk(v[4] == 1'b0, "R10", v, 8'h80);

    chk(hbad == 0, "R11", hbad, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule